// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block converts a 39-bit virtual address into a 56-bit physical address by walking a three-level page table stored in memory. A caller presents a translate request together with the current translation-control word and privilege mode. When translation is active, the walker fetches one 64-bit table entry per level through a request/response memory port, with a single read outstanding. It finishes early when it meets a leaf entry at the top or middle level (a 1 GiB or 2 MiB page).

Each walk ends with a one-cycle `done` pulse. That pulse carries the physical address and a fault flag. The block caches nothing, sets no access or dirty bits, and checks no permissions apart from leaf detection. It therefore suits a TLB refill path or a debug translation port that issues one request at a time.

Top module: `pt_walk3`

## Requirements
- R1: When bit 63 of `xlat_ctl` is 0, an accepted request completes with `done` one cycle after acceptance. `pa_out` equals the virtual address zero-extended to 56 bits, `fault` is 0, and no memory read is issued.
- R2: When `priv_lvl` is 3 (machine), translation is bypassed exactly as in R1, even with bit 63 of `xlat_ctl` set.
- R3: The virtual address splits into the offset in bits 11:0 and three 9-bit indices: bits 38:30 (level 2), 29:21 (level 1) and 20:12 (level 0). The first read uses word address ((`xlat_ctl`[43:0] << 12) + index2*8) >> 3. A non-leaf entry gives the next base, (entry[53:10] << 12). The next read is at (that base + next index*8) >> 3.
- R4: An entry is a leaf when bit 1 (readable) or bit 3 (executable) is set. A leaf at level 0 yields {entry[53:10], va[11:0]} after three reads.
- R5: A leaf at level 2 ends the walk after one read, with {entry[53:28], va[29:0]}.
- R6: A leaf at level 1 ends the walk after two reads, with {entry[53:19], va[20:0]}.
- R7: An entry with bit 0 (valid) clear ends the walk at once. The completion has `fault`=1 and `pa_out`=0, and no further read is made.
- R8: A valid non-leaf entry at level 0 ends the walk with `fault`=1 and `pa_out`=0 after three reads.
- R9: `mem_req_valid` stays high with a stable address until `mem_req_ready`. The walker then waits for `mem_rsp_valid` before issuing the next read, so at most one read is outstanding.
- R10: `done` is high for exactly one cycle per completed request. `pa_out` and `fault` hold their values until the next completion.
- R11: `tr_valid` is ignored while a walk is in progress. Such a request neither changes the result nor produces a completion.
- R12: A synchronous reset, including one in the middle of a walk, returns the walker to idle with `done`, `fault` and `mem_req_valid` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tr_valid | input | 1 | Translate request, sampled while idle |
| tr_vaddr | input | 39 | Virtual address to translate |
| xlat_ctl | input | 64 | Translation control: bit 63 enables translation, bits 43:0 give the root table page number |
| priv_lvl | input | 2 | Current privilege mode, 3 = machine |
| pa_out | output | 56 | Translated physical address, valid with `done` |
| done | output | 1 | One-cycle completion strobe |
| fault | output | 1 | Walk fault, qualified by `done` |
| mem_req_valid | output | 1 | Table-entry read request |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 53 | Word address of the entry (byte address >> 3) |
| mem_rsp_valid | input | 1 | Read data valid strobe |
| mem_rsp_data | input | 64 | Table entry returned by memory |

## Verification
A corrupted level counter or base register shows up at once in the word address of the next table read. The bench checks that address against the value it computes from the table it built, and the bad read then gives a wrong or faulting `pa_out` at the following completion. A stuck or mis-sequenced controller shows up as a missing, doubled or extra `done` pulse, or as a read count different from the one the leaf level implies. Every walk therefore compares the read count, the read addresses and the cycle after `done` within a few cycles of the fault.

// File: rtl/pt_walk3_pkg.sv
package pt_walk3_pkg;

   // walk controller states
   typedef enum logic [1:0] {
      WK_IDLE  = 2'd0,
      WK_ISSUE = 2'd1,
      WK_WAIT  = 2'd2
   } walk_state_t;

   // entry flag positions (fixed by the table format)
   localparam int ENT_VALID = 0;
   localparam int ENT_READ  = 1;
   localparam int ENT_EXEC  = 3;

endpackage

// File: rtl/pt_walk3_mode.sv
module pt_walk3_mode #(
   parameter int XLEN      = 64,
   parameter int PA_W      = 56,
   parameter int OFF_W     = 12,
   parameter int ROOT_W    = 44,
   parameter int MODE_BIT  = 63,
   parameter int PRIV_W    = 2,
   parameter int MACH_PRIV = 3
) (
   input  logic [XLEN-1:0]   ctl,
   input  logic [PRIV_W-1:0] priv,
   output logic              xlate_on,
   output logic [PA_W-1:0]   root_base
);

   if (ROOT_W + OFF_W != PA_W) begin : g_bad_root
      $error("pt_walk3_mode: root field plus offset must equal PA width");
   end
   if (MODE_BIT >= XLEN) begin : g_bad_mode
      $error("pt_walk3_mode: mode bit outside control word");
   end

   logic unused_ctl;
   assign unused_ctl = ^ctl;

   assign xlate_on  = ctl[MODE_BIT] && (priv != PRIV_W'(MACH_PRIV));
   assign root_base = {ctl[ROOT_W-1:0], {OFF_W{1'b0}}};

endmodule

// File: rtl/pt_walk3_addr.sv
module pt_walk3_addr #(
   parameter int XLEN  = 64,
   parameter int PA_W  = 56,
   parameter int VPN_W = 9,
   localparam int SHIFT = $clog2(XLEN/8),
   localparam int WA_W  = PA_W - SHIFT
) (
   input  logic [PA_W-1:0]  base,
   input  logic [VPN_W-1:0] vpn,
   output logic [WA_W-1:0]  waddr
);

   if ((XLEN % 8) != 0) begin : g_bad_xlen
      $error("pt_walk3_addr: entry width must be whole bytes");
   end

   logic unused_lo;
   assign unused_lo = ^base[SHIFT-1:0];

   // byte address base + vpn*entry_bytes, expressed in entry-sized words
   assign waddr = base[PA_W-1:SHIFT] + WA_W'(vpn);

endmodule

// File: rtl/pt_walk3_compose.sv
module pt_walk3_compose #(
   parameter int VA_W   = 39,
   parameter int PA_W   = 56,
   parameter int LEVELS = 3,
   parameter int VPN_W  = 9,
   parameter int OFF_W  = 12,
   parameter int PPN_W  = 44,
   localparam int LVL_W = $clog2(LEVELS)
) (
   input  logic [VA_W-1:0]  va,
   input  logic [PPN_W-1:0] ppn,
   input  logic [LVL_W-1:0] lvl,
   output logic [PA_W-1:0]  pa
);

   if (PPN_W + OFF_W != PA_W) begin : g_bad_pa
      $error("pt_walk3_compose: page number plus offset must equal PA width");
   end

   logic [PA_W-1:0] cand [LEVELS];

   // a leaf at level l keeps l page indices plus the offset from the VA
   for (genvar l = 0; l < LEVELS; l++) begin : g_lvl
      localparam int KEEP = OFF_W + l*VPN_W;
      if (l == 0) begin : g_page
         assign cand[l] = {ppn, va[OFF_W-1:0]};
      end else begin : g_super
         assign cand[l] = {ppn[PPN_W-1:l*VPN_W], va[KEEP-1:0]};
      end
   end

   always_comb begin
      pa = cand[0];
      for (int l = 1; l < LEVELS; l++) begin
         if (lvl == LVL_W'(l)) pa = cand[l];
      end
   end

endmodule

// File: rtl/pt_walk3.sv
module pt_walk3
   import pt_walk3_pkg::*;
#(
   parameter int XLEN      = 64,
   parameter int VA_W      = 39,
   parameter int PA_W      = 56,
   parameter int LEVELS    = 3,
   parameter int VPN_W     = 9,
   parameter int OFF_W     = 12,
   parameter int PPN_LSB   = 10,
   parameter int PPN_W     = 44,
   parameter int MODE_BIT  = 63,
   parameter int PRIV_W    = 2,
   parameter int MACH_PRIV = 3,
   localparam int WA_W     = PA_W - $clog2(XLEN/8),
   localparam int LVL_W    = $clog2(LEVELS)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              tr_valid,
   input  logic [VA_W-1:0]   tr_vaddr,
   input  logic [XLEN-1:0]   xlat_ctl,
   input  logic [PRIV_W-1:0] priv_lvl,
   output logic [PA_W-1:0]   pa_out,
   output logic              done,
   output logic              fault,
   output logic              mem_req_valid,
   input  logic              mem_req_ready,
   output logic [WA_W-1:0]   mem_req_addr,
   input  logic              mem_rsp_valid,
   input  logic [XLEN-1:0]   mem_rsp_data
);

   if (LEVELS*VPN_W + OFF_W != VA_W) begin : g_bad_va
      $error("pt_walk3: VA width must equal levels*index + offset");
   end
   if (PPN_LSB + PPN_W > XLEN) begin : g_bad_ppn
      $error("pt_walk3: page number field exceeds entry width");
   end
   if (VA_W > PA_W) begin : g_bad_bare
      $error("pt_walk3: bypass needs PA at least as wide as VA");
   end

   walk_state_t      state;
   logic [LVL_W-1:0] lvl;
   logic [VA_W-1:0]  va_q;
   logic [PA_W-1:0]  base_q;
   logic             done_q, fault_q;
   logic [PA_W-1:0]  pa_q;

   logic             xlate_on;
   logic [PA_W-1:0]  root_base;
   logic [VPN_W-1:0] vpn_sel;
   logic [PPN_W-1:0] ent_ppn;
   logic [PA_W-1:0]  leaf_pa;
   logic             ent_v, ent_leaf;
   logic             unused_rsp;

   assign unused_rsp = ^mem_rsp_data;

   pt_walk3_mode #(
      .XLEN(XLEN), .PA_W(PA_W), .OFF_W(OFF_W), .ROOT_W(PA_W-OFF_W),
      .MODE_BIT(MODE_BIT), .PRIV_W(PRIV_W), .MACH_PRIV(MACH_PRIV)
   ) mode_i (
      .ctl(xlat_ctl), .priv(priv_lvl), .xlate_on(xlate_on), .root_base(root_base)
   );

   // page index for the current level
   always_comb begin
      vpn_sel = va_q[OFF_W +: VPN_W];
      for (int l = 1; l < LEVELS; l++) begin
         if (lvl == LVL_W'(l)) vpn_sel = va_q[OFF_W + l*VPN_W +: VPN_W];
      end
   end

   pt_walk3_addr #(
      .XLEN(XLEN), .PA_W(PA_W), .VPN_W(VPN_W)
   ) addr_i (
      .base(base_q), .vpn(vpn_sel), .waddr(mem_req_addr)
   );

   assign ent_ppn  = mem_rsp_data[PPN_LSB +: PPN_W];
   assign ent_v    = mem_rsp_data[ENT_VALID];
   assign ent_leaf = mem_rsp_data[ENT_READ] | mem_rsp_data[ENT_EXEC];

   pt_walk3_compose #(
      .VA_W(VA_W), .PA_W(PA_W), .LEVELS(LEVELS), .VPN_W(VPN_W),
      .OFF_W(OFF_W), .PPN_W(PPN_W)
   ) comp_i (
      .va(va_q), .ppn(ent_ppn), .lvl(lvl), .pa(leaf_pa)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         state   <= WK_IDLE;
         lvl     <= '0;
         va_q    <= '0;
         base_q  <= '0;
         done_q  <= 1'b0;
         fault_q <= 1'b0;
         pa_q    <= '0;
      end else begin
         done_q <= 1'b0;
         unique case (state)
            WK_IDLE: begin
               if (tr_valid) begin
                  va_q <= tr_vaddr;
                  if (xlate_on) begin
                     base_q <= root_base;
                     lvl    <= LVL_W'(LEVELS-1);
                     state  <= WK_ISSUE;
                  end else begin
                     pa_q    <= PA_W'(tr_vaddr);
                     fault_q <= 1'b0;
                     done_q  <= 1'b1;
                  end
               end
            end
            WK_ISSUE: begin
               if (mem_req_ready) state <= WK_WAIT;
            end
            WK_WAIT: begin
               if (mem_rsp_valid) begin
                  if (!ent_v || (!ent_leaf && lvl == '0)) begin
                     pa_q    <= '0;
                     fault_q <= 1'b1;
                     done_q  <= 1'b1;
                     state   <= WK_IDLE;
                  end else if (ent_leaf) begin
                     pa_q    <= leaf_pa;
                     fault_q <= 1'b0;
                     done_q  <= 1'b1;
                     state   <= WK_IDLE;
                  end else begin
                     base_q <= {ent_ppn, {OFF_W{1'b0}}};
                     lvl    <= lvl - LVL_W'(1);
                     state  <= WK_ISSUE;
                  end
               end
            end
            default: state <= WK_IDLE;
         endcase
      end
   end

   assign mem_req_valid = (state == WK_ISSUE);
   assign done          = done_q;
   assign fault         = fault_q;
   assign pa_out        = pa_q;

   // R9
   req_hold_chk: assert property (@(posedge clk) disable iff (rst)
      mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

   // R10
   done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
      done |=> !done);

   // R1
   bypass_nomem_chk: assert property (@(posedge clk) disable iff (rst)
      (state == WK_IDLE) && tr_valid && !xlate_on |=> done && !fault && !mem_req_valid);

   // R7
   fault_with_done_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(fault) |-> done && (pa_out == '0));

   // R9
   no_req_while_wait_chk: assert property (@(posedge clk) disable iff (rst)
      (state == WK_WAIT) && !mem_rsp_valid |=> !mem_req_valid);

endmodule

// File: tb/pt_walk3_tb_top.sv
`timescale 1ns/1ps
module pt_walk3_tb_top;

   logic        clk = 1'b0;
   logic        rst;
   logic        tr_valid;
   logic [38:0] tr_vaddr;
   logic [63:0] xlat_ctl;
   logic [1:0]  priv_lvl;
   logic [55:0] pa_out;
   logic        done, fault;
   logic        mem_req_valid, mem_req_ready;
   logic [52:0] mem_req_addr;
   logic        mem_rsp_valid;
   logic [63:0] mem_rsp_data;

   int n_tests = 0;
   int n_fail  = 0;

   always #2 clk = ~clk;

   pt_walk3 dut_i (
      .clk(clk), .rst(rst), .tr_valid(tr_valid), .tr_vaddr(tr_vaddr),
      .xlat_ctl(xlat_ctl), .priv_lvl(priv_lvl), .pa_out(pa_out),
      .done(done), .fault(fault), .mem_req_valid(mem_req_valid),
      .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
      .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
   );

   // ---------------- memory model ----------------
   logic [63:0] pt [longint unsigned];
   logic [63:0] addr_log [64];
   int          rd_cnt = 0;
   int          rsp_lat = 1;
   bit          slow_ready = 0;
   logic [31:0] cyc = '0;
   bit          pend = 0;
   int          tmr = 0;
   logic [63:0] pend_addr = '0;

   assign mem_req_ready = !slow_ready || cyc[0];

   always @(posedge clk) begin
      cyc <= cyc + 1;
      mem_rsp_valid <= 1'b0;
      if (rst) begin
         pend <= 0;
      end else if (pend) begin
         if (tmr == 0) begin
            mem_rsp_valid <= 1'b1;
            mem_rsp_data  <= pt.exists(pend_addr) ? pt[pend_addr] : 64'h0;
            pend <= 0;
         end else tmr <= tmr - 1;
      end else if (mem_req_valid && mem_req_ready) begin
         pend      <= 1;
         tmr       <= rsp_lat;
         pend_addr <= 64'(mem_req_addr);
         addr_log[rd_cnt % 64] <= 64'(mem_req_addr);
         rd_cnt    <= rd_cnt + 1;
      end
   end

   // ---------------- helpers ----------------
   task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   function automatic logic [63:0] waddr(input logic [63:0] base, input logic [8:0] idx);
      return (base + 64'(idx) * 8) >> 3;
   endfunction

   function automatic logic [63:0] nonleaf(input logic [43:0] ppn);
      return {10'h0, ppn, 10'h001};
   endfunction

   function automatic logic [63:0] leaf(input logic [43:0] ppn, input logic [3:0] flg);
      return {10'h0, ppn, 6'h0, flg};
   endfunction

   function automatic logic [55:0] splice(input logic [43:0] ppn, input logic [38:0] va, input int keep);
      logic [55:0] m;
      m = (56'h1 << keep) - 56'h1;
      return ({ppn, 12'h0} & ~m) | (56'(va) & m);
   endfunction

   logic [55:0] got_pa;
   logic        got_fault;
   int          got_lat;
   int          got_reads;
   int          rd_base;

   task automatic run_xlate(input logic [38:0] va, input logic [63:0] ctl, input logic [1:0] pv,
                            input int hold, input logic [38:0] alt_va);
      bit seen = 0;
      int n = 0;
      int h = hold;
      @(negedge clk);
      rd_base  = rd_cnt;
      tr_valid = 1'b1; tr_vaddr = va; xlat_ctl = ctl; priv_lvl = pv;
      while (!seen && n < 300) begin
         @(negedge clk);
         n++;
         if (h > 0) begin tr_vaddr = alt_va; h--; end
         else tr_valid = 1'b0;
         if (done) begin
            seen = 1; got_pa = pa_out; got_fault = fault; got_lat = n;
         end
      end
      tr_valid = 1'b0;
      got_reads = rd_cnt - rd_base;
      check(seen, "R10 completion seen", 64'(seen), 64'h1);
      @(negedge clk);
      check(!done, "R10 done one cycle", 64'(done), 64'h0);
   endtask

   // table layout shared by walk scenarios
   localparam logic [43:0] ROOT = 44'h0_0008_0000;
   localparam logic [63:0] CTL_ON = {1'b1, 19'h0, ROOT};
   localparam logic [38:0] VA4K = {9'd5, 9'h1A3, 9'h077, 12'hABC};
   localparam logic [43:0] P_A = 44'h0_0008_0001;
   localparam logic [43:0] P_B = 44'h0_0008_0002;
   localparam logic [43:0] P_C = 44'hF12_3456_7890;

   // ---------------- scenarios ----------------
   task automatic t_reset();
      @(negedge clk);
      check(!done && !fault, "R12 reset outputs", {62'h0, done, fault}, 64'h0);
      check(!mem_req_valid, "R12 reset no request", 64'(mem_req_valid), 64'h0);
   endtask

   task automatic t_bypass_off();
      logic [38:0] va = 39'h12_3456_789A;
      run_xlate(va, {1'b0, 19'h0, ROOT}, 2'd1, 0, '0);
      check(got_pa == 56'(va), "R1 bypass address", 64'(got_pa), 64'(va));
      check(got_lat == 1 && !got_fault, "R1 bypass latency/fault", 64'(got_lat), 64'h1);
      check(got_reads == 0, "R1 no memory read", 64'(got_reads), 64'h0);
   endtask

   task automatic t_bypass_mach();
      logic [38:0] va = 39'h7F_FFFF_F001;
      run_xlate(va, CTL_ON, 2'd3, 0, '0);
      check(got_pa == 56'(va) && !got_fault, "R2 machine bypass", 64'(got_pa), 64'(va));
      check(got_reads == 0, "R2 no memory read", 64'(got_reads), 64'h0);
   endtask

   task automatic t_walk4k(input bit slow, input int lat);
      logic [63:0] a2, a1, a0;
      logic [55:0] exp_pa;
      slow_ready = slow; rsp_lat = lat;
      a2 = waddr({8'h0, ROOT, 12'h0}, 9'd5);
      a1 = waddr({8'h0, P_A, 12'h0}, 9'h1A3);
      a0 = waddr({8'h0, P_B, 12'h0}, 9'h077);
      pt[a2] = nonleaf(P_A);
      pt[a1] = nonleaf(P_B);
      pt[a0] = leaf(P_C, 4'b0011);
      exp_pa = {P_C, 12'hABC};
      run_xlate(VA4K, CTL_ON, 2'd1, 0, '0);
      check(got_pa == exp_pa && !got_fault, "R4 level-0 leaf address", 64'(got_pa), 64'(exp_pa));
      check(got_reads == 3, "R4 three reads", 64'(got_reads), 64'd3);
      check(addr_log[rd_base % 64] == a2, "R3 level-2 entry address", addr_log[rd_base % 64], a2);
      check(addr_log[(rd_base+1) % 64] == a1, "R3 level-1 entry address", addr_log[(rd_base+1) % 64], a1);
      check(addr_log[(rd_base+2) % 64] == a0, "R3 level-0 entry address", addr_log[(rd_base+2) % 64], a0);
      if (slow)
         check(got_lat > 9, "R9 walk waits on ready/response", 64'(got_lat), 64'd10);
      slow_ready = 0; rsp_lat = 1;
   endtask

   task automatic t_giga();
      logic [38:0] va = {9'd7, 9'h155, 9'h0AA, 12'h321};
      logic [43:0] g = 44'hABC_DE12_3456;
      logic [55:0] exp_pa;
      pt[waddr({8'h0, ROOT, 12'h0}, 9'd7)] = leaf(g, 4'b1001);
      exp_pa = splice(g, va, 30);
      run_xlate(va, CTL_ON, 2'd0, 0, '0);
      check(got_pa == exp_pa && !got_fault, "R5 gigapage address", 64'(got_pa), 64'(exp_pa));
      check(got_reads == 1, "R5 one read", 64'(got_reads), 64'd1);
   endtask

   task automatic t_mega();
      logic [38:0] va = {9'd3, 9'h0F0, 9'h1FF, 12'hFFF};
      logic [43:0] d = 44'h0_0009_0000;
      logic [43:0] m = 44'h123_4567_89AB;
      logic [55:0] exp_pa;
      pt[waddr({8'h0, ROOT, 12'h0}, 9'd3)] = nonleaf(d);
      pt[waddr({8'h0, d, 12'h0}, 9'h0F0)]  = leaf(m, 4'b0011);
      exp_pa = splice(m, va, 21);
      run_xlate(va, CTL_ON, 2'd1, 0, '0);
      check(got_pa == exp_pa && !got_fault, "R6 megapage address", 64'(got_pa), 64'(exp_pa));
      check(got_reads == 2, "R6 two reads", 64'(got_reads), 64'd2);
   endtask

   task automatic t_invalid();
      logic [38:0] va = {9'd9, 9'h011, 9'h022, 12'h000};
      logic [43:0] e = 44'h0_000A_0000;
      pt[waddr({8'h0, ROOT, 12'h0}, 9'd9)] = nonleaf(e);
      pt[waddr({8'h0, e, 12'h0}, 9'h011)]  = leaf(44'h55, 4'b0010); // R set, V clear
      run_xlate(va, CTL_ON, 2'd1, 0, '0);
      check(got_fault && got_pa == '0, "R7 invalid entry fault", {got_fault, 63'(got_pa)}, 64'h8000_0000_0000_0000);
      check(got_reads == 2, "R7 walk stops at invalid", 64'(got_reads), 64'd2);
   endtask

   task automatic t_nonleaf0();
      logic [38:0] va = {9'd10, 9'h003, 9'h004, 12'h010};
      logic [43:0] f = 44'h0_000B_0000;
      logic [43:0] h = 44'h0_000C_0000;
      pt[waddr({8'h0, ROOT, 12'h0}, 9'd10)] = nonleaf(f);
      pt[waddr({8'h0, f, 12'h0}, 9'h003)]   = nonleaf(h);
      pt[waddr({8'h0, h, 12'h0}, 9'h004)]   = nonleaf(44'h1);
      run_xlate(va, CTL_ON, 2'd1, 0, '0);
      check(got_fault && got_pa == '0, "R8 non-leaf at level 0", 64'(got_fault), 64'h1);
      check(got_reads == 3, "R8 three reads", 64'(got_reads), 64'd3);
   endtask

   task automatic t_reset_mid();
      bit any_done = 0;
      @(negedge clk);
      tr_valid = 1'b1; tr_vaddr = VA4K; xlat_ctl = CTL_ON; priv_lvl = 2'd1;
      @(negedge clk); tr_valid = 1'b0;
      @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      @(negedge clk);
      rst = 1'b0;
      check(!done && !fault && !mem_req_valid, "R12 reset mid-walk",
            {61'h0, done, fault, mem_req_valid}, 64'h0);
      for (int i = 0; i < 10; i++) begin
         @(negedge clk);
         if (done || mem_req_valid) any_done = 1;
      end
      check(!any_done, "R12 idle after reset", 64'(any_done), 64'h0);
      t_bypass_off();
   endtask

   task automatic t_ignore();
      bit extra = 0;
      int r0;
      run_xlate(VA4K, CTL_ON, 2'd1, 3, 39'h00_0000_1000);
      check(got_pa == {P_C, 12'hABC} && !got_fault, "R11 busy request ignored",
            64'(got_pa), 64'({P_C, 12'hABC}));
      r0 = rd_cnt;
      for (int i = 0; i < 12; i++) begin
         @(negedge clk);
         if (done) extra = 1;
      end
      check(!extra && rd_cnt == r0 && got_reads == 3, "R11 no extra completion",
            64'(extra), 64'h0);
   endtask

   // ---------------- main ----------------
   initial begin
      rst = 1'b1; tr_valid = 1'b0; tr_vaddr = '0; xlat_ctl = '0; priv_lvl = '0;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      t_reset();
      t_bypass_off();
      t_bypass_mach();
      t_walk4k(0, 1);
      t_walk4k(1, 3);
      t_giga();
      t_mega();
      t_invalid();
      t_nonleaf0();
      t_reset_mid();
      t_ignore();
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      #(4 * 150000);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule